// File: doc/BRIEF.md
# E1 Basic Frame Alignment Tracker

This block locates and holds basic frame alignment on a serial E1 receive stream. One bit arrives on `rx_bit` at each rising edge of `clk`, which acts as the recovered bit clock. A frame is 256 bits, made of 32 timeslots of 8 bits. Timeslot 0 carries the 8-bit alignment word in every other frame. In the frames between, timeslot 0 carries a non-alignment word whose second bit is always 1. The tracker slides across the stream one bit at a time looking for the alignment pattern. It qualifies a candidate with the second bit of the following non-alignment word, and then with a second alignment word one double-frame later. Only after both does it declare lock.

While locked, the tracker checks every expected alignment word. Three bad words in a row drop lock. A manual reframe request drops lock at the next expected alignment word. Either event starts a new search at the bit that follows, and gives a one-cycle restart pulse that clears any framing logic further downstream. The block also reports the position of the bit now on `rx_bit` (timeslot, bit within timeslot, and whether the current frame is an alignment-word frame). It also gives the remote alarm bit for the transmit side, which is 1 whenever lock is absent.

Top module: `e1_frame_align`

## Requirements
- R1: While `rst` is high at a clock edge, and right after it, `frame_locked` is 0, `rai_tx` is 1, `restart_pulse` is 0, and `slot_idx`, `bit_idx` and `fas_frame` are all 0.
- R2: In search, a candidate is taken when the seven most recent bits, oldest first, equal 0011011. These are timeslot-0 bits 1 to 7 of an alignment frame, where bit 0 is the first bit transmitted in the timeslot. Bit 0 (the spare international bit) is never compared, so its value has no effect on acquisition or lock.
- R3: After a candidate, bit 1 of timeslot 0 in the next frame (the non-alignment frame) must be 1. If it is 0, the candidate is dropped and the search continues from the following bit, so a stream whose non-alignment words carry 0 there never locks.
- R4: Lock requires a correct alignment word exactly 512 bits after the candidate. `frame_locked` rises in the cycle after that word's last bit is sampled, which is 512 edges after the candidate's last bit.
- R5: After a candidate is accepted, `slot_idx`, `bit_idx` and `fas_frame` give the position of the bit now on `rx_bit`. For a frame position p (0 to 255), `slot_idx` = p/8 and `bit_idx` = p mod 8. `fas_frame` is 1 in the frame that carries the alignment word. The position wraps from 255 to 0 and toggles `fas_frame`.
- R6: While locked, three consecutive expected alignment words that mismatch drop lock in the cycle after the third. Two bad words, or a good word between bad ones, keep lock.
- R7: While locked, only bits 1 to 7 of the alignment word are judged. A changing bit 0 never counts as an error.
- R8: `restart_pulse` is high for exactly one cycle after each loss of lock and after each accepted manual reframe, and is never high two cycles running.
- R9: A `reframe_req` pulse while locked is held until the next expected alignment word's last bit. At that point lock drops, whatever the word's value. The search starts with the next bit, so relock on a clean stream comes 1024 edges later.
- R10: A `reframe_req` while a candidate is being qualified drops the candidate at once and gives a restart pulse. A request while searching has no effect.
- R11: `rai_tx` is 1 in every cycle `frame_locked` is 0, and 0 in every cycle it is 1.
- R12: A manual reframe that falls on the same bit as the third consecutive bad alignment word gives a single restart. There is one restart pulse, and relock follows 1024 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial data bit |
| reframe_req | input | 1 | Manual reframe request, one cycle |
| frame_locked | output | 1 | Basic frame alignment held |
| rai_tx | output | 1 | Remote alarm bit for the transmit side |
| restart_pulse | output | 1 | One-cycle clear for downstream framing |
| slot_idx | output | 5 | Timeslot of the bit now on rx_bit |
| bit_idx | output | 3 | Bit within the timeslot of the bit now on rx_bit |
| fas_frame | output | 1 | Current frame carries the alignment word |

## Verification
Two functions can land on the same bit. One is loss of lock through the third bad alignment word. The other is a manual reframe, which is also acted on at an alignment-word boundary. The bench corrupts three alignment words in a row and raises `reframe_req` on the very bit that completes the third. It judges the result by counting restart pulses over the whole episode (exactly one is allowed), and by checking that relock comes exactly 1024 edges later, which proves the search was started once rather than twice.

// File: rtl/e1_align_pkg.sv
package e1_align_pkg;

    localparam int SLOTS       = 32;
    localparam int SLOT_BITS   = 8;
    localparam int FRAME_BITS  = SLOTS * SLOT_BITS;
    localparam int POS_W       = $clog2(FRAME_BITS);
    localparam int SLOT_W      = $clog2(SLOTS);
    localparam int BIT_W       = $clog2(SLOT_BITS);
    localparam int LOSS_COUNT  = 3;
    localparam int ERR_W       = $clog2(LOSS_COUNT + 1);
    localparam int FAS_W       = 7;
    localparam logic [FAS_W-1:0] FAS_PATTERN = 7'b0011011;
    localparam int NFAS_CHECK_POS = 1;

    typedef enum logic [1:0] {
        ST_SEARCH   = 2'd0,
        ST_CHK_NFAS = 2'd1,
        ST_CHK_FAS  = 2'd2,
        ST_LOCKED   = 2'd3
    } align_state_e;

    typedef struct packed {
        logic             fas_frame;
        logic [POS_W-1:0] pos;
    } frame_pos_t;

    typedef struct packed {
        logic fas_ok;
        logic nfas_bit;
        logic at_fas_end;
        logic at_nfas_chk;
    } align_event_t;

    function automatic logic window_matches(input logic [FAS_W-1:0] win,
                                            input logic [FAS_W-1:0] pat);
        return win == pat;
    endfunction

endpackage

// File: rtl/e1_fas_window.sv
module e1_fas_window
    import e1_align_pkg::*;
#(
    parameter int               WIN_W   = FAS_W,
    parameter logic [WIN_W-1:0] PATTERN = FAS_PATTERN
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit,
    output logic fas_ok
);
    localparam int HIST_W = WIN_W - 1;

    logic [HIST_W-1:0] hist_q;
    logic [WIN_W-1:0]  win;

    // Oldest bit at the top; the live bit completes the window.
    assign win    = {hist_q, rx_bit};
    assign fas_ok = window_matches(win, PATTERN);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '1;
        end else begin
            hist_q <= win[HIST_W-1:0];
        end
    end

    // After reset the history is all ones, so no partial window can match.
    AST_NO_MATCH_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !fas_ok) else $error("match on reset history"); // R2

endmodule

// File: rtl/e1_pos_counter.sv
module e1_pos_counter
    import e1_align_pkg::*;
#(
    parameter int N_SLOTS   = SLOTS,
    parameter int N_BITS    = SLOT_BITS,
    parameter int NFAS_POS  = NFAS_CHECK_POS
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             load,
    output logic [$clog2(N_SLOTS*N_BITS)-1:0] pos,
    output logic                             fas_frame,
    output logic                             at_fas_end,
    output logic                             at_nfas_chk
);
    localparam int LEN   = N_SLOTS * N_BITS;
    localparam int PW    = $clog2(LEN);
    localparam logic [PW-1:0] LAST_POS = PW'(LEN - 1);
    localparam logic [PW-1:0] LOAD_POS = PW'(N_BITS);
    localparam logic [PW-1:0] END_TS0  = PW'(N_BITS - 1);
    localparam logic [PW-1:0] CHK_POS  = PW'(NFAS_POS);

    logic [PW-1:0] pos_q, pos_d;
    logic          ff_q, ff_d;

    always_comb begin
        pos_d = pos_q + PW'(1);
        ff_d  = ff_q;
        if (load) begin
            // The candidate's last bit is on rx_bit now: the next one opens timeslot 1.
            pos_d = LOAD_POS;
            ff_d  = 1'b1;
        end else if (pos_q == LAST_POS) begin
            pos_d = '0;
            ff_d  = ~ff_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            ff_q  <= 1'b0;
        end else begin
            pos_q <= pos_d;
            ff_q  <= ff_d;
        end
    end

    assign pos         = pos_q;
    assign fas_frame   = ff_q;
    assign at_fas_end  = ff_q && (pos_q == END_TS0);
    assign at_nfas_chk = !ff_q && (pos_q == CHK_POS);

    AST_WRAP_TOGGLES_FRAME: assert property (@(posedge clk) disable iff (rst)
        (!load && pos_q == LAST_POS) |=> (pos_q == '0 && ff_q != $past(ff_q)))
        else $error("frame wrap"); // R5

endmodule

// File: rtl/e1_align_fsm.sv
module e1_align_fsm
    import e1_align_pkg::*;
#(
    parameter int LOSS_N = LOSS_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  align_event_t ev,
    input  logic         reframe_req,
    output logic         load_pos,
    output logic         locked,
    output logic         rai,
    output logic         restart_pulse
);
    localparam int EW = $clog2(LOSS_N + 1);
    localparam logic [EW-1:0] LAST_ERR = EW'(LOSS_N - 1);

    align_state_e  state_q, state_d;
    logic [EW-1:0] err_q, err_d;
    logic          pend_q, pend_d;
    logic          pulse_q, pulse_d;
    logic          rai_q;

    always_comb begin
        state_d  = state_q;
        err_d    = err_q;
        pend_d   = pend_q;
        pulse_d  = 1'b0;
        load_pos = 1'b0;
        unique case (state_q)
            ST_SEARCH: begin
                if (!reframe_req && ev.fas_ok) begin
                    load_pos = 1'b1;
                    state_d  = ST_CHK_NFAS;
                end
            end
            ST_CHK_NFAS: begin
                if (reframe_req) begin
                    state_d = ST_SEARCH;
                    pulse_d = 1'b1;
                end else if (ev.at_nfas_chk) begin
                    state_d = ev.nfas_bit ? ST_CHK_FAS : ST_SEARCH;
                end
            end
            ST_CHK_FAS: begin
                err_d  = '0;
                pend_d = 1'b0;
                if (reframe_req) begin
                    state_d = ST_SEARCH;
                    pulse_d = 1'b1;
                end else if (ev.at_fas_end) begin
                    state_d = ev.fas_ok ? ST_LOCKED : ST_SEARCH;
                end
            end
            ST_LOCKED: begin
                pend_d = pend_q | reframe_req;
                if (ev.at_fas_end) begin
                    err_d = ev.fas_ok ? '0 : err_q + EW'(1);
                    if ((!ev.fas_ok && err_q == LAST_ERR) || pend_q || reframe_req) begin
                        state_d = ST_SEARCH;
                        pulse_d = 1'b1;
                        err_d   = '0;
                        pend_d  = 1'b0;
                    end
                end
            end
            default: state_d = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEARCH;
            err_q   <= '0;
            pend_q  <= 1'b0;
            pulse_q <= 1'b0;
            rai_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            pend_q  <= pend_d;
            pulse_q <= pulse_d;
            rai_q   <= (state_d != ST_LOCKED);
        end
    end

    assign locked        = (state_q == ST_LOCKED);
    assign rai           = rai_q;
    assign restart_pulse = pulse_q;

    AST_LOCK_NEEDS_FAS: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(ev.at_fas_end && ev.fas_ok)) else $error("lock without FAS"); // R4
    AST_RAI_TRACKS_LOCK: assert property (@(posedge clk) disable iff (rst)
        rai == !locked) else $error("rai mismatch"); // R11
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        restart_pulse |=> !restart_pulse) else $error("double pulse"); // R8
    AST_LOSS_PULSES: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> restart_pulse) else $error("silent loss"); // R6

    always_ff @(posedge clk) begin
        if (!rst) begin
            AST_ERR_BOUNDED: assert (err_q < EW'(LOSS_N)) else $error("error count"); // R6
        end
    end

endmodule

// File: rtl/e1_frame_align.sv
module e1_frame_align
    import e1_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    input  logic              reframe_req,
    output logic              frame_locked,
    output logic              rai_tx,
    output logic              restart_pulse,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              fas_frame
);
    frame_pos_t   fpos;
    align_event_t ev;
    logic         load_pos;
    logic         fas_ok;
    logic         at_fas_end;
    logic         at_nfas_chk;

    e1_fas_window #(
        .WIN_W   (FAS_W),
        .PATTERN (FAS_PATTERN)
    ) u_window (
        .clk    (clk),
        .rst    (rst),
        .rx_bit (rx_bit),
        .fas_ok (fas_ok)
    );

    e1_pos_counter #(
        .N_SLOTS  (SLOTS),
        .N_BITS   (SLOT_BITS),
        .NFAS_POS (NFAS_CHECK_POS)
    ) u_counter (
        .clk         (clk),
        .rst         (rst),
        .load        (load_pos),
        .pos         (fpos.pos),
        .fas_frame   (fpos.fas_frame),
        .at_fas_end  (at_fas_end),
        .at_nfas_chk (at_nfas_chk)
    );

    assign ev.fas_ok      = fas_ok;
    assign ev.nfas_bit    = rx_bit;
    assign ev.at_fas_end  = at_fas_end;
    assign ev.at_nfas_chk = at_nfas_chk;

    e1_align_fsm #(
        .LOSS_N (LOSS_COUNT)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .ev            (ev),
        .reframe_req   (reframe_req),
        .load_pos      (load_pos),
        .locked        (frame_locked),
        .rai           (rai_tx),
        .restart_pulse (restart_pulse)
    );

    assign slot_idx  = fpos.pos[POS_W-1:BIT_W];
    assign bit_idx   = fpos.pos[BIT_W-1:0];
    assign fas_frame = fpos.fas_frame;

endmodule

// File: tb/test_e1_frame_align.sv
module test_e1_frame_align;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b1;
    logic       reframe_req = 1'b0;
    logic       frame_locked, rai_tx, restart_pulse, fas_frame;
    logic [4:0] slot_idx;
    logic [2:0] bit_idx;

    e1_frame_align i_e1_frame_align (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .reframe_req(reframe_req),
        .frame_locked(frame_locked), .rai_tx(rai_tx), .restart_pulse(restart_pulse),
        .slot_idx(slot_idx), .bit_idx(bit_idx), .fas_frame(fas_frame)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;
    int off    = 0;
    int idx    = 0;
    int last   = -1;
    int rf_at  = -1;
    int nfas_b2 = 1;
    int bad_lo = -1, bad_hi = -1, hole = -1;
    int pulse_cnt = 0;
    int ever_locked = 0;
    int cycles = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (bit %0d)", req, act, exp, last);
        end
    endtask

    // Bit at stream index s; frame 0 carries the alignment word.
    function automatic logic gen(input int s);
        int f = s / 256;
        int p = s % 256;
        logic [6:0] pat = 7'b0011011;
        logic b;
        if (p >= 8) return 1'b1;
        if (f % 2 == 0) begin
            if (p == 0) return logic'((f / 2) % 2);   // spare bit changes every double frame
            b = pat[7 - p];
            if (f >= bad_lo && f <= bad_hi && f != hole && p == 3) b = ~b;
            return b;
        end
        return (p == 1) ? logic'(nfas_b2) : 1'b1;
    endfunction

    task automatic step();
        rx_bit      = gen(idx + off);
        reframe_req = (idx == rf_at);
        @(posedge clk);
        @(negedge clk);
        last = idx;
        idx++;
        if (restart_pulse) pulse_cnt++;
        if (frame_locked) ever_locked = 1;
    endtask

    task automatic run_to(input int n);
        while (last < n) step();
    endtask

    task automatic do_reset(input int new_off);
        rst = 1'b1; rx_bit = 1'b1; reframe_req = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        off = new_off; idx = 0; last = -1; rf_at = -1;
        nfas_b2 = 1; bad_lo = -1; bad_hi = -1; hole = -1;
        pulse_cnt = 0; ever_locked = 0;
    endtask

    function automatic int first_cand(input int o);
        int n = ((7 - o) % 512 + 512) % 512;
        if (n < 6) n += 512;
        return n;
    endfunction

    initial begin : watchdog
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int n0, e, s;
        @(negedge clk); @(negedge clk);
        // R1 / R11: reset state
        check("R1 locked", frame_locked, 0);
        check("R1 pulse", restart_pulse, 0);
        check("R1 slot", slot_idx, 0);
        check("R1 bit", bit_idx, 0);
        check("R1 fas_frame", fas_frame, 0);
        check("R11 rai in reset", rai_tx, 1);

        // R2 R4 R5 R11: offset sweep, spare bit toggling throughout
        for (int o = 0; o < 512; o += 23) begin
            do_reset(o);
            n0 = first_cand(o);
            run_to(n0 + 511);
            check("R4 not yet locked", frame_locked, 0);
            check("R11 rai before lock", rai_tx, 1);
            run_to(n0 + 512);
            check("R4 locked", frame_locked, 1);
            check("R11 rai after lock", rai_tx, 0);
            run_to(n0 + 512 + 37 + o);
            s = last + off + 1;
            check("R5 slot", slot_idx, (s % 256) / 8);
            check("R5 bit", bit_idx, s % 8);
            check("R5 fas_frame", fas_frame, ((s % 512) < 256) ? 1 : 0);
        end

        // R3: non-alignment bit 1 held at 0 -> never locks
        do_reset(100);
        nfas_b2 = 0;
        run_to(3000);
        check("R3 never locked", ever_locked, 0);
        nfas_b2 = 1;
        n0 = first_cand(100);   // real candidates recur every 512 bits
        s = ((last + 1 + off - 7 + 511) / 512) * 512 + 7;   // next candidate stream index
        run_to(s - off + 512);
        check("R3 locks once bit is 1", frame_locked, 1);

        // R6 R7 R8 R11: two bad, good, three bad (frames 6..16, 10 good)
        do_reset(100);
        bad_lo = 6; bad_hi = 16; hole = 10;
        run_to(14 * 256 + 7 - off);
        check("R6 two bad then hole keeps lock", frame_locked, 1);
        check("R7 spare bit ignored", pulse_cnt, 0);
        e = 16 * 256 + 7 - off;
        run_to(e - 1);
        check("R6 locked before third", frame_locked, 1);
        run_to(e);
        check("R6 lost after third bad", frame_locked, 0);
        check("R8 pulse on loss", restart_pulse, 1);
        check("R11 rai on loss", rai_tx, 1);
        run_to(e + 1);
        check("R8 pulse one cycle", restart_pulse, 0);
        run_to(e + 1023);
        check("R6 relock not early", frame_locked, 0);
        run_to(e + 1024);
        check("R6 relock", frame_locked, 1);

        // R9: manual reframe while locked
        do_reset(100);
        e = 8 * 256 + 7 - off;
        rf_at = e - 100;
        run_to(e - 1);
        check("R9 held until FAS end", frame_locked, 1);
        check("R9 no early pulse", pulse_cnt, 0);
        run_to(e);
        check("R9 dropped", frame_locked, 0);
        check("R8 pulse on reframe", restart_pulse, 1);
        run_to(e + 1023);
        check("R9 relock not early", frame_locked, 0);
        run_to(e + 1024);
        check("R9 relock", frame_locked, 1);

        // R10: reframe during qualification, and in search
        do_reset(100);
        n0 = first_cand(100);
        rf_at = 5;
        run_to(6);
        check("R10 search ignores reframe", pulse_cnt, 0);
        rf_at = n0 + 100;
        run_to(n0 + 100);
        check("R10 pulse", restart_pulse, 1);
        run_to(n0 + 512);
        check("R10 candidate dropped", frame_locked, 0);
        run_to(n0 + 1023);
        check("R10 relock not early", frame_locked, 0);
        run_to(n0 + 1024);
        check("R10 relock", frame_locked, 1);

        // R12: reframe on the bit of the third bad word
        do_reset(100);
        bad_lo = 8; bad_hi = 12;
        e = 12 * 256 + 7 - off;
        rf_at = e;
        run_to(e);
        check("R12 lost", frame_locked, 0);
        check("R12 pulse", restart_pulse, 1);
        run_to(e + 1023);
        check("R12 single pulse", pulse_cnt, 1);
        check("R12 relock not early", frame_locked, 0);
        run_to(e + 1024);
        check("R12 relock", frame_locked, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule